// File: doc/BRIEF.md
# Two-Read Result and Status Port

This block sits between a converter's result latch and an 8-bit host bus. A 13-bit two's complement result is too wide for the bus, so the host fetches it in two reads. The first read returns the upper part, sign-extended to a full byte. The second read returns the lower eight bits. An internal byte pointer tracks which half comes next. Each completed data read advances the pointer, and every conversion end sends it back to the upper half, so a fresh result always starts with its upper byte.

A select input chooses between result bytes and a status byte. The status byte shows four things: the converter's busy flag, the byte pointer, a flag that the latest result has been latched, and a data-ready flag. Data-ready is set at conversion end. It is cleared by a new conversion start, by any completed data read, or by any completed status read. The select input is sampled once, when an access begins, and holds for the whole access. Pointer and flag updates wait until the access ends, so the value returned during a read stays stable.

All inputs are synchronous to `clk`. A read access is the span of cycles in which both `cs_n` and `rd_n` are low. The bus protocol is plain strobe-based with no back-pressure. A read never stalls, and the host may start the next access on the cycle after the previous one ends.

Top module: `conv_byte_reader`

## Requirements
- R1: `bus_oe` is 1 exactly in cycles where `cs_n` and `rd_n` are both low, and 0 otherwise.
- R2: In a data read with the pointer at the upper half, `bus_q` = {four copies of result[12], result[11:8]}. With the pointer at the lower half, `bus_q` = result[7:0].
- R3: Each completed data access toggles the byte pointer (0 = upper next, 1 = lower next), so consecutive data reads alternate upper, lower, upper.
- R4: A `conv_end` pulse sets the byte pointer to 0, whatever state it was in.
- R5: A status read returns bit 6 = `conv_busy`, bit 2 = byte pointer, and bits 7, 5, 4, 3 = 0.
- R6: Status bit 1 (latched) is set by `conv_end` and cleared by `conv_start`. If both pulses arrive in the same cycle, `conv_start` wins.
- R7: Status bit 0 (ready) is set by `conv_end`. It is cleared by `conv_start`, by the end of a data access, and by the end of a status access.
- R8: `data_sel` (1 = result byte, 0 = status byte) is sampled in the first cycle of an access. Later changes within that access affect neither the returned byte nor the update at its end.
- R9: Pointer and flag updates take effect on the clock edge that ends an access. If `conv_end` falls on that same edge, the result is pointer = 0 and ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_sel | input | 1 | 1 selects result bytes, 0 selects the status byte |
| result | input | 13 | Latched two's complement conversion result |
| conv_busy | input | 1 | Conversion in progress |
| conv_start | input | 1 | One-cycle pulse: conversion started |
| conv_end | input | 1 | One-cycle pulse: conversion ended, result latched |
| bus_q | output | 8 | Byte presented to the host |
| bus_oe | output | 1 | Output driver enable |

## Verification
The critical overlap is a conversion end landing on the same edge that closes a data read. That edge has two competing effects: the read wants to toggle the pointer and clear ready, while the conversion end wants to send the pointer home and set ready. The bench provokes this by raising `conv_end` in the same cycle that the strobe is released. It then reads status and expects pointer 0 with ready and latched set. A second overlap pairs `conv_start` with the end of a data read, and is judged by ready reading 0 while the pointer still toggles.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned ST_BUSY  = 6;
  localparam int unsigned ST_PTR   = 2;
  localparam int unsigned ST_LATCH = 1;
  localparam int unsigned ST_READY = 0;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } sel_e;
endpackage

// File: rtl/cbr_access.sv
module cbr_access (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic data_sel,
  output logic active,
  output logic acc_begin,
  output logic acc_end,
  output logic mode_now,
  output logic mode_held
);
  import cbr_pkg::*;

  logic act_q;
  logic sel_q;

  assign active    = ~cs_n & ~rd_n;
  assign acc_begin = active & ~act_q;
  assign acc_end   = ~active & act_q;
  assign mode_now  = acc_begin ? data_sel : sel_q;
  assign mode_held = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sel_q <= SEL_DATA;
    end else begin
      act_q <= active;
      if (acc_begin) sel_q <= data_sel;
    end
  end
endmodule

// File: rtl/cbr_flags.sv
module cbr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic conv_end,
  input  logic acc_end,
  input  logic mode_held,
  output logic ptr,
  output logic latched,
  output logic ready
);
  import cbr_pkg::*;

  logic data_done;
  assign data_done = acc_end & (mode_held == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= 1'b0;
      latched <= 1'b0;
      ready   <= 1'b0;
    end else begin
      if (conv_end)       ptr <= 1'b0;
      else if (data_done) ptr <= ~ptr;

      if (conv_start)    latched <= 1'b0;
      else if (conv_end) latched <= 1'b1;

      if (conv_start)    ready <= 1'b0;
      else if (conv_end) ready <= 1'b1;
      else if (acc_end)  ready <= 1'b0;
    end
  end
endmodule

// File: rtl/cbr_outmux.sv
module cbr_outmux #(
  parameter int unsigned RES_W = 13,
  parameter int unsigned BUS_W = 8
) (
  input  logic [RES_W-1:0] result,
  input  logic             ptr,
  input  logic             mode,
  input  logic             busy,
  input  logic             latched,
  input  logic             ready,
  output logic [BUS_W-1:0] byte_q
);
  import cbr_pkg::*;

  localparam int unsigned HI_W  = RES_W - BUS_W;
  localparam int unsigned EXT_W = BUS_W - HI_W;

  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;
  logic [BUS_W-1:0] st_byte;

  assign hi_byte[HI_W-1:0] = result[RES_W-1:BUS_W];

  genvar g;
  generate
    for (g = 0; g < EXT_W; g++) begin : g_ext
      assign hi_byte[HI_W+g] = result[RES_W-1];
    end
  endgenerate

  assign lo_byte = result[BUS_W-1:0];

  always_comb begin
    st_byte           = '0;
    st_byte[ST_BUSY]  = busy;
    st_byte[ST_PTR]   = ptr;
    st_byte[ST_LATCH] = latched;
    st_byte[ST_READY] = ready;
  end

  always_comb begin
    if (mode == SEL_STATUS) byte_q = st_byte;
    else if (ptr)           byte_q = lo_byte;
    else                    byte_q = hi_byte;
  end
endmodule

// File: rtl/conv_byte_reader.sv
module conv_byte_reader #(
  parameter int unsigned RES_W = 13,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             data_sel,
  input  logic [RES_W-1:0] result,
  input  logic             conv_busy,
  input  logic             conv_start,
  input  logic             conv_end,
  output logic [BUS_W-1:0] bus_q,
  output logic             bus_oe
);
  logic active, acc_begin, acc_end, mode_now, mode_held;
  logic ptr, latched, ready;

  cbr_access u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .data_sel  (data_sel),
    .active    (active),
    .acc_begin (acc_begin),
    .acc_end   (acc_end),
    .mode_now  (mode_now),
    .mode_held (mode_held)
  );

  cbr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_end   (conv_end),
    .acc_end    (acc_end),
    .mode_held  (mode_held),
    .ptr        (ptr),
    .latched    (latched),
    .ready      (ready)
  );

  cbr_outmux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_outmux (
    .result  (result),
    .ptr     (ptr),
    .mode    (mode_now),
    .busy    (conv_busy),
    .latched (latched),
    .ready   (ready),
    .byte_q  (bus_q)
  );

  assign bus_oe = active;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic acc_begin,
  input logic acc_end,
  input logic mode_held,
  input logic conv_start,
  input logic conv_end,
  input logic ptr,
  input logic latched,
  input logic ready
);
  p_ptr_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !ptr);

  p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && mode_held && !conv_end) |=> (ptr != $past(ptr)));

  p_latch_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && !conv_start) |=> latched);

  p_latch_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !latched);

  p_ready_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !ready);

  p_ready_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && !conv_end) |=> !ready);

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !acc_begin) |=> $stable(mode_held));

  p_coincide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && conv_end && !conv_start) |=> (!ptr && ready));
endmodule

bind conv_byte_reader cbr_checker u_cbr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .acc_begin  (acc_begin),
  .acc_end    (acc_end),
  .mode_held  (mode_held),
  .conv_start (conv_start),
  .conv_end   (conv_end),
  .ptr        (ptr),
  .latched    (latched),
  .ready      (ready)
);

// File: tb/test_conv_byte_reader.sv
module test_conv_byte_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        data_sel = 1'b1;
  logic [12:0] result = '0;
  logic        conv_busy = 1'b0;
  logic        conv_start = 1'b0;
  logic        conv_end = 1'b0;
  logic [7:0]  bus_q;
  logic        bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  conv_byte_reader i_conv_byte_reader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .data_sel(data_sel),
    .result(result), .conv_busy(conv_busy), .conv_start(conv_start),
    .conv_end(conv_end), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_of(input logic [12:0] v);
    int s;
    s = (v >= 13'd4096) ? int'(v) - 8192 : int'(v);
    return 8'((s >>> 8) & 255);
  endfunction

  function automatic logic [7:0] st_of(input bit busy, input bit p, input bit l, input bit r);
    return 8'(busy * 64 + p * 4 + l * 2 + r);
  endfunction

  task automatic pulse_end();
    @(negedge clk); conv_end = 1'b1;
    @(negedge clk); conv_end = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
  endtask

  // side: 0 none, 1 flip data_sel mid access, 2 conv_end on release, 3 conv_start on release
  task automatic do_read(input logic sel, input int side, output logic [7:0] d, output logic oe);
    @(negedge clk); data_sel = sel;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    if (side == 1) begin
      data_sel = ~sel;
      @(negedge clk);
    end
    d = bus_q; oe = bus_oe;
    cs_n = 1'b1; rd_n = 1'b1;
    if (side == 2) conv_end = 1'b1;
    if (side == 3) conv_start = 1'b1;
    @(negedge clk);
    conv_end = 1'b0; conv_start = 1'b0;
    data_sel = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    check("R1 reset oe", int'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enable needs both strobes
    cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
    check("R1 cs only", int'(bus_oe), 0);
    cs_n = 1'b1; rd_n = 1'b0; @(negedge clk);
    check("R1 rd only", int'(bus_oe), 0);
    rd_n = 1'b1; @(negedge clk);

    // R5 reset status
    do_read(1'b0, 0, d, oe);
    check("R1 oe during read", int'(oe), 1);
    check("R5 reset status", int'(d), int'(st_of(0, 0, 0, 0)));

    // R6/R7 set by conv_end
    result = 13'h1A5C;
    pulse_end();
    do_read(1'b0, 0, d, oe);
    check("R6 R7 after end", int'(d), int'(st_of(0, 0, 1, 1)));
    do_read(1'b0, 0, d, oe);
    check("R7 cleared by status read", int'(d), int'(st_of(0, 0, 1, 0)));

    // R6/R7 start clears, R5 busy bit
    conv_busy = 1'b1;
    pulse_start();
    do_read(1'b0, 0, d, oe);
    check("R5 R6 busy", int'(d), int'(st_of(1, 0, 0, 0)));
    conv_busy = 1'b0;
    result = 13'h1A5C;
    pulse_end();

    // R3 sequence and R7 clear by data read
    do_read(1'b1, 0, d, oe);
    check("R2 R3 first high", int'(d), int'(hi_of(13'h1A5C)));
    do_read(1'b0, 0, d, oe);
    check("R5 R7 ptr low", int'(d), int'(st_of(0, 1, 1, 0)));
    do_read(1'b1, 0, d, oe);
    check("R3 second low", int'(d), 8'h5C);
    do_read(1'b1, 0, d, oe);
    check("R3 third high", int'(d), int'(hi_of(13'h1A5C)));

    // R4: pointer back home after conversion end
    pulse_end();
    do_read(1'b0, 0, d, oe);
    check("R4 ptr reset", int'(d), int'(st_of(0, 0, 1, 1)));

    // R8: data_sel flipped mid access
    do_read(1'b1, 1, d, oe);
    check("R8 byte held", int'(d), int'(hi_of(13'h1A5C)));
    do_read(1'b0, 1, d, oe);
    check("R8 ptr toggled", int'(d), int'(st_of(0, 1, 1, 0)));
    do_read(1'b1, 0, d, oe);
    check("R8 status read no toggle", int'(d), 8'h5C);

    // R9: conv_end on read release
    pulse_end();
    do_read(1'b1, 2, d, oe);
    do_read(1'b0, 0, d, oe);
    check("R9 coincident end", int'(d), int'(st_of(0, 0, 1, 1)));

    // R7/R3: conv_start on data read release
    pulse_end();
    do_read(1'b1, 3, d, oe);
    do_read(1'b0, 0, d, oe);
    check("R7 R3 coincident start", int'(d), int'(st_of(0, 1, 0, 0)));

    // R2 exhaustive sweep
    for (int v = 0; v < 8192; v++) begin
      result = 13'(v);
      pulse_end();
      do_read(1'b1, 0, d, oe);
      check("R2 high byte", int'(d), int'(hi_of(13'(v))));
      do_read(1'b1, 0, d, oe);
      check("R2 low byte", int'(d), v & 255);
    end

    finish_run();
  end
endmodule